// File: doc/BRIEF.md
# Store Address and Data Formatter

This unit sits between the decode stage and the store queue of a 64-bit core. For each decoded store it forms the effective address from a base register and one of three offset sources. It also lines up the stored bytes on a 64-bit memory bus and derives the per-lane write enables. For update-form stores it raises a base-register writeback request. The result passes through one output register with a valid/ready handshake, so a stalled consumer simply holds the formatted store in place.

Stores of 1, 2, 4 or 8 bytes are supported. The bytes come from the low end of the source register. Memory order is big-endian, so the most significant stored byte lands at the lowest address. A reverse flag swaps that order for little-endian data. Lane k of the bus carries the byte whose address has low three bits equal to k. A store that runs past lane 7 keeps only the lanes that fit, and the split is left to the consumer.

Top module: `stfmt_unit`

## Requirements
- R1: On a non-update store (upd=0) the base is zero when ra_idx is 0, and ra_val otherwise.
- R2: On an update store (upd=1) the base is always ra_val, even when ra_idx is 0. When ra_idx is non-zero, wb_en is 1, wb_idx equals ra_idx and the value to write back is out_addr.
- R3: An update store with ra_idx 0 sets bad_form=1 and wb_en=0. Every non-update store has bad_form=0 and wb_en=0.
- R4: With form code 0 the offset is the 16-bit immediate sign-extended to 64 bits. The addition wraps modulo 2^64.
- R5: With form code 1 the offset is imm[15:2] followed by two zero bits, sign-extended from bit 15. imm[1:0] has no effect on the address.
- R6: With form codes 2 and 3 the offset is rb_val, and imm has no effect.
- R7: Size codes 0,1,2,3 select N = 1,2,4,8 bytes. Without reversal, the byte at address EA+i is byte N-1-i of rs_val, where byte 0 is rs_val[7:0].
- R8: With brev=1, the byte at address EA+i is byte i of rs_val. For N=1 the result equals the unreversed one.
- R9: Lane k is out_data[8k+7:8k]. Let off = EA[2:0]. out_be[k] is 1 exactly for lanes off through min(off+N-1,7). Bytes beyond lane 7 are dropped, and disabled lanes carry zero.
- R10: in_ready = !out_valid || out_ready. An accepted store appears on the outputs in the next cycle. While out_valid=1 and out_ready=0, all outputs hold.
- R11: After reset out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded store present |
| in_ready | output | 1 | Unit can accept a store |
| ra_idx | input | 5 | Base register number |
| ra_val | input | 64 | Base register value |
| rb_val | input | 64 | Index register value |
| imm | input | 16 | Immediate field |
| form | input | 2 | 0 displacement, 1 scaled displacement, 2/3 indexed |
| upd | input | 1 | Update form |
| size | input | 2 | 0=1, 1=2, 2=4, 3=8 bytes |
| brev | input | 1 | Byte-reversed store |
| rs_val | input | 64 | Source data register value |
| out_valid | output | 1 | Formatted store valid |
| out_ready | input | 1 | Consumer accepts the store |
| out_addr | output | 64 | Effective address, also the writeback value |
| out_data | output | 64 | Lane-aligned write data |
| out_be | output | 8 | Lane write enables |
| wb_en | output | 1 | Base register writeback request |
| wb_idx | output | 5 | Register to write back |
| bad_form | output | 1 | Update form with register field 0 |

## Verification
On every cycle the assertions check several properties. Held outputs must stay stable under backpressure, and an accepted store must show up one cycle later. Disabled lanes must be zero, and every valid store must enable at least one lane. A full aligned doubleword must enable all lanes, and writeback and invalid-form must never be raised together. Whether the address, the byte order and the lane placement are correct for a given operand set can only be shown by the bench's scenarios. These cover the zero-base rule, the scaled immediate with junk low bits, address wrap, every size with and without reversal, and stores that run past lane 7, all compared against a behavioural model of the byte layout.

// File: rtl/stfmt_pkg.sv
package stfmt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    AF_DISP    = 2'd0,
    AF_DSCALED = 2'd1,
    AF_INDEX   = 2'd2,
    AF_INDEX2  = 2'd3
  } addr_form_e;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } st_size_e;

endpackage

// File: rtl/stfmt_agen.sv
module stfmt_agen
  import stfmt_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMMW  = 16,
  parameter int RIDXW = 5
) (
  input  logic [RIDXW-1:0] ra_idx,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  rb_val,
  input  logic [IMMW-1:0]  imm,
  input  addr_form_e       form,
  input  logic             upd,
  output logic [XLEN-1:0]  ea,
  output logic             wb_req,
  output logic             bad_form
);

  localparam int EXTW = XLEN - IMMW;

  logic             ra_is_zero;
  logic [XLEN-1:0]  base;
  logic [XLEN-1:0]  off_disp;
  logic [XLEN-1:0]  off_scaled;
  logic [XLEN-1:0]  offset;

  assign ra_is_zero = (ra_idx == '0);

  // update forms always take the register, others treat field 0 as zero
  assign base = (upd || !ra_is_zero) ? ra_val : '0;

  assign off_disp   = {{EXTW{imm[IMMW-1]}}, imm};
  assign off_scaled = {{EXTW{imm[IMMW-1]}}, imm[IMMW-1:2], 2'b00};

  always_comb begin
    unique case (form)
      AF_DISP:    offset = off_disp;
      AF_DSCALED: offset = off_scaled;
      default:    offset = rb_val;
    endcase
  end

  assign ea       = base + offset;
  assign wb_req   = upd && !ra_is_zero;
  assign bad_form = upd && ra_is_zero;

endmodule

// File: rtl/stfmt_lanes.sv
module stfmt_lanes
  import stfmt_pkg::*;
#(
  parameter int BUSB = 8
) (
  input  st_size_e                  size,
  input  logic                      brev,
  input  logic [$clog2(BUSB)-1:0]   off,
  input  logic [BYTE_W*BUSB-1:0]    rs,
  output logic [BYTE_W*BUSB-1:0]    data,
  output logic [BUSB-1:0]           be
);

  localparam int LOFFW = $clog2(BUSB);
  localparam int CNTW  = LOFFW + 2;

  logic [CNTW-1:0]   nbytes;
  logic [BYTE_W-1:0] rs_bytes [BUSB];
  logic [BYTE_W-1:0] mem_bytes [BUSB];

  assign nbytes = CNTW'(1) << size;

  // memory-order byte sequence: mem_bytes[i] goes to address EA+i
  for (genvar i = 0; i < BUSB; i++) begin : g_seq
    logic [CNTW-1:0] rev_pos;
    assign rs_bytes[i] = rs[BYTE_W*i +: BYTE_W];
    assign rev_pos     = nbytes - CNTW'(1) - CNTW'(i);
    assign mem_bytes[i] = brev ? rs_bytes[i] : rs_bytes[rev_pos[LOFFW-1:0]];
  end

  // place the sequence on the bus starting at the address offset
  for (genvar k = 0; k < BUSB; k++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    logic              lane_en;
    always_comb begin
      lane_q  = '0;
      lane_en = 1'b0;
      for (int i = 0; i < BUSB; i++) begin
        if ((CNTW'(off) + CNTW'(i) == CNTW'(k)) && (CNTW'(i) < nbytes)) begin
          lane_q  = mem_bytes[i];
          lane_en = 1'b1;
        end
      end
    end
    assign data[BYTE_W*k +: BYTE_W] = lane_q;
    assign be[k]                    = lane_en;
  end

endmodule

// File: rtl/stfmt_pipe.sv
module stfmt_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);

  logic         valid_q, valid_d;
  logic [W-1:0] payload_q;
  logic         load;

  assign in_ready = !valid_q || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    valid_d = valid_q;
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    payload_q <= '0;
    else if (load) payload_q <= in_payload;
  end

  assign out_valid   = valid_q;
  assign out_payload = payload_q;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)));

  a_r10_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/stfmt_unit.sv
module stfmt_unit
  import stfmt_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMMW  = 16,
  parameter int RIDXW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RIDXW-1:0]  ra_idx,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  input  logic [IMMW-1:0]   imm,
  input  logic [1:0]        form,
  input  logic              upd,
  input  logic [1:0]        size,
  input  logic              brev,
  input  logic [XLEN-1:0]   rs_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_addr,
  output logic [XLEN-1:0]   out_data,
  output logic [XLEN/8-1:0] out_be,
  output logic              wb_en,
  output logic [RIDXW-1:0]  wb_idx,
  output logic              bad_form
);

  localparam int BUSB  = XLEN / BYTE_W;
  localparam int LOFFW = $clog2(BUSB);

  typedef struct packed {
    logic [XLEN-1:0]  addr;
    logic [XLEN-1:0]  data;
    logic [BUSB-1:0]  be;
    logic             wb;
    logic [RIDXW-1:0] idx;
    logic             bad;
  } fmt_t;

  logic [XLEN-1:0] ea_c;
  logic            wb_c;
  logic            bad_c;
  logic [XLEN-1:0] data_c;
  logic [BUSB-1:0] be_c;
  fmt_t            fmt_c;
  fmt_t            fmt_q;

  stfmt_agen #(.XLEN(XLEN), .IMMW(IMMW), .RIDXW(RIDXW)) u_agen (
    .ra_idx   (ra_idx),
    .ra_val   (ra_val),
    .rb_val   (rb_val),
    .imm      (imm),
    .form     (addr_form_e'(form)),
    .upd      (upd),
    .ea       (ea_c),
    .wb_req   (wb_c),
    .bad_form (bad_c)
  );

  stfmt_lanes #(.BUSB(BUSB)) u_lanes (
    .size (st_size_e'(size)),
    .brev (brev),
    .off  (ea_c[LOFFW-1:0]),
    .rs   (rs_val),
    .data (data_c),
    .be   (be_c)
  );

  always_comb begin
    fmt_c.addr = ea_c;
    fmt_c.data = data_c;
    fmt_c.be   = be_c;
    fmt_c.wb   = wb_c;
    fmt_c.idx  = ra_idx;
    fmt_c.bad  = bad_c;
  end

  stfmt_pipe #(.W($bits(fmt_t))) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_payload  (fmt_c),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_payload (fmt_q)
  );

  assign out_addr = fmt_q.addr;
  assign out_data = fmt_q.data;
  assign out_be   = fmt_q.be;
  assign wb_en    = fmt_q.wb;
  assign wb_idx   = fmt_q.idx;
  assign bad_form = fmt_q.bad;

  // R3: writeback and invalid-form never coexist
  a_r3_wb_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && bad_form) |-> !wb_en);

  // R9: every formatted store enables its first lane at least
  a_r9_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_be != '0));

  // R9: aligned full-width store covers every lane
  a_r9_full_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd3 && ea_c[LOFFW-1:0] == '0) |-> (be_c == '1));

  for (genvar k = 0; k < BUSB; k++) begin : g_chk
    // R9: disabled lanes carry zero
    a_r9_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_be[k]) |-> (out_data[BYTE_W*k +: BYTE_W] == '0));
  end

endmodule

// File: tb/stfmt_unit_test.sv
module stfmt_unit_test;

  typedef struct {
    logic [4:0]  ra_idx;
    logic [63:0] ra_val;
    logic [63:0] rb_val;
    logic [15:0] imm;
    logic [1:0]  form;
    logic        upd;
    logic [1:0]  size;
    logic        brev;
    logic [63:0] rs;
    string       tag;
  } txn_t;

  typedef struct {
    logic [63:0] addr;
    logic [63:0] data;
    logic [7:0]  be;
    logic        wb;
    logic [4:0]  idx;
    logic        bad;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  ra_idx = '0;
  logic [63:0] ra_val = '0, rb_val = '0, rs_val = '0;
  logic [15:0] imm = '0;
  logic [1:0]  form = '0, size = '0;
  logic        upd = 1'b0, brev = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_addr, out_data;
  logic [7:0]  out_be;
  logic        wb_en, bad_form;
  logic [4:0]  wb_idx;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  txn_t stim[$];
  exp_t model[$];

  always #4 clk = ~clk;

  stfmt_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ra_idx(ra_idx), .ra_val(ra_val), .rb_val(rb_val), .imm(imm),
    .form(form), .upd(upd), .size(size), .brev(brev), .rs_val(rs_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .out_be(out_be), .wb_en(wb_en), .wb_idx(wb_idx),
    .bad_form(bad_form)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t predict(txn_t t);
    exp_t e;
    logic [63:0] base, off, ea;
    int n;
    base = (t.upd || t.ra_idx != 0) ? t.ra_val : 64'd0;
    if (t.form == 2'd0)      off = 64'($signed(t.imm));
    else if (t.form == 2'd1) off = 64'($signed({t.imm[15:2], 2'b00}));
    else                     off = t.rb_val;
    ea = base + off;
    n = 1 << t.size;
    e.addr = ea; e.data = '0; e.be = '0;
    for (int i = 0; i < n; i++) begin
      int lane;
      logic [7:0] b;
      lane = int'(ea[2:0]) + i;
      b = t.brev ? 8'(t.rs >> (8 * i)) : 8'(t.rs >> (8 * (n - 1 - i)));
      if (lane < 8) begin
        e.data[8*lane +: 8] = b;
        e.be[lane] = 1'b1;
      end
    end
    e.wb  = t.upd && t.ra_idx != 0;
    e.bad = t.upd && t.ra_idx == 0;
    e.idx = t.ra_idx;
    e.tag = t.tag;
    return e;
  endfunction

  function automatic txn_t mk(logic [4:0] ri, logic [63:0] ra, logic [63:0] rb,
                              logic [15:0] im, logic [1:0] f, logic u,
                              logic [1:0] s, logic br, logic [63:0] rs, string tag);
    txn_t t;
    t.ra_idx = ri; t.ra_val = ra; t.rb_val = rb; t.imm = im; t.form = f;
    t.upd = u; t.size = s; t.brev = br; t.rs = rs; t.tag = tag;
    return t;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    bit in_fire, out_fire;
    txn_t cur;
    int cyc;

    d = 64'h1122_3344_5566_7788;
    stim.push_back(mk(5'd0, 64'hDEAD_0000_0000_0000, 0, 16'h0010, 2'd0, 0, 2'd3, 0, d, "R1 zero base"));
    stim.push_back(mk(5'd5, 64'h1000, 0, 16'h0020, 2'd0, 0, 2'd3, 0, d, "R1 reg base"));
    stim.push_back(mk(5'd5, 64'h1000, 0, 16'hFFF0, 2'd0, 0, 2'd3, 0, d, "R4 negative disp"));
    stim.push_back(mk(5'd4, 64'hFFFF_FFFF_FFFF_FFF8, 0, 16'h0008, 2'd0, 0, 2'd3, 0, d, "R4 wrap"));
    stim.push_back(mk(5'd3, 64'h2000, 0, 16'h0007, 2'd1, 0, 2'd3, 0, d, "R5 low bits ignored"));
    stim.push_back(mk(5'd3, 64'h2000, 0, 16'h8001, 2'd1, 0, 2'd3, 0, d, "R5 negative scaled"));
    stim.push_back(mk(5'd3, 64'h2000, 64'h123, 16'h7777, 2'd2, 0, 2'd2, 0, d, "R6 indexed"));
    stim.push_back(mk(5'd0, 64'h40, 64'h8, 16'h5555, 2'd3, 0, 2'd0, 0, d, "R6 code3 zero base"));
    stim.push_back(mk(5'd0, 64'h3000, 0, 16'h0004, 2'd0, 1, 2'd2, 0, d, "R3 update field zero"));
    stim.push_back(mk(5'd0, 64'h3000, 0, 16'h0004, 2'd0, 1, 2'd2, 0, d, "R2 update base kept"));
    stim.push_back(mk(5'd7, 64'h3000, 64'h10, 16'h0, 2'd2, 1, 2'd3, 0, d, "R2 writeback"));
    for (int s = 0; s < 4; s++) begin
      stim.push_back(mk(5'd1, 64'h100, 0, 16'h0, 2'd0, 0, 2'(s), 0, d, "R7 aligned size"));
      stim.push_back(mk(5'd1, 64'h100, 0, 16'h0, 2'd0, 0, 2'(s), 1, d, "R8 reversed size"));
    end
    stim.push_back(mk(5'd1, 64'h106, 0, 16'h0, 2'd0, 0, 2'd2, 0, d, "R9 crossing plain"));
    stim.push_back(mk(5'd1, 64'h103, 0, 16'h0, 2'd0, 0, 2'd1, 1, d, "R9 mid lane reversed"));
    stim.push_back(mk(5'd1, 64'h107, 0, 16'h0, 2'd0, 0, 2'd3, 1, d, "R9 last lane"));
    for (int i = 0; i < 400; i++) begin
      stim.push_back(mk(5'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                        16'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
                        1'($urandom), {$urandom, $urandom}, "R7 random"));
    end

    repeat (3) @(negedge clk);
    chk("R11", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "out_valid after reset", 64'(out_valid), 64'd0);
    chk("R11", "in_ready after reset", 64'(in_ready), 64'd1);

    in_fire = 0; out_fire = 0; cyc = 0;
    while (stim.size() > 0 || model.size() > 0 || in_fire) begin
      if (out_fire) void'(model.pop_front());
      if (in_fire)  model.push_back(predict(cur));
      chk("R10", "out_valid", 64'(out_valid), 64'(model.size() > 0));
      if (out_valid && model.size() > 0) begin
        exp_t e;
        e = model[0];
        chk(e.tag, "addr", out_addr, e.addr);
        chk(e.tag, "data", out_data, e.data);
        chk(e.tag, "be", 64'(out_be), 64'(e.be));
        chk(e.tag, "wb_en", 64'(wb_en), 64'(e.wb));
        chk(e.tag, "bad_form", 64'(bad_form), 64'(e.bad));
        if (e.wb) chk(e.tag, "wb_idx", 64'(wb_idx), 64'(e.idx));
      end
      out_ready = (cyc < 60) ? 1'b1 : ((cyc % 37) < 5 ? 1'b0 : 1'($urandom_range(0, 3) != 0));
      if (stim.size() > 0 && $urandom_range(0, 4) != 0) begin
        cur = stim.pop_front();
        in_valid = 1'b1;
        ra_idx = cur.ra_idx; ra_val = cur.ra_val; rb_val = cur.rb_val;
        imm = cur.imm; form = cur.form; upd = cur.upd; size = cur.size;
        brev = cur.brev; rs_val = cur.rs;
      end else begin
        in_valid = 1'b0;
      end
      #1;
      chk("R10", "in_ready", 64'(in_ready), 64'(!out_valid || out_ready));
      in_fire  = in_valid && (!out_valid || out_ready);
      out_fire = out_valid && out_ready;
      if (in_valid && !in_fire) stim.push_front(cur);
      @(negedge clk);
      cyc++;
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule